// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four pins drive it: a test clock, a mode-select line, a serial data input and an active-low asynchronous reset. It returns one serial data output with a matching enable. A sixteen-state controller follows the mode-select line on each rising clock edge. It moves a three-bit instruction through an instruction register and then places one data register between the serial input and output. The data register is chosen by the instruction.

Four data paths are built in. A one-cell pass-through register, a 32-bit identification word, and an 8-bit private register that can read and write core-side parallel ports. The boundary chain lives outside the block. For that chain the block provides capture, shift and update strobes, a serial feed to the chain and a serial return from it. Two mode outputs tell the core to float its outputs, or to let the boundary cells drive the pins.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is in Test-Logic-Reset, `ir_o` reads 3'b001 (the identification opcode) and `tdo_en` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, which restores `ir_o` to 3'b001.
- R3: State changes follow the standard sixteen-state graph on rising `tck` edges. The bench walks Run-Test/Idle, Select, Capture, Shift, Exit1, Update and back for both the instruction and data branches.
- R4: In Capture-IR the instruction shift stage loads 3'b001, so the first three bits out of `tdo` in Shift-IR are 1, 0, 0 (LSB first).
- R5: `ir_o` changes only on the rising edge that leaves Update-IR (or in Test-Logic-Reset). Opcodes: 000 boundary drive, 010 boundary sample, 001 identification, 011 private register, and 111, 100, 101, 110 pass-through.
- R6: With opcode 001, the identification register captures 32'h204D0067 and shifts it out LSB first.
- R7: With opcodes 111, 100, 101 or 110, a single cell captures 0 and then repeats `tdi` one clock later.
- R8: With opcodes 000 or 010, `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly in Capture-DR, Shift-DR and Update-DR. `bsr_si` carries `tdi` and `tdo` carries `bsr_so`. For other opcodes all three strobes stay low.
- R9: With opcode 011, the 8-bit private register captures `usr_in` in Capture-DR and shifts it out LSB first. `usr_out` takes the shifted-in value only on leaving Update-DR and holds otherwise.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only in Shift-IR and Shift-DR; elsewhere `tdo` is 0.
- R11: `core_hiz` is 1 exactly while opcode 101 is current; `bnd_drive` is 1 exactly while opcode 000 is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| ir_o | output | 3 | Current instruction |
| core_hiz | output | 1 | Core output disable |
| bnd_drive | output | 1 | Boundary cells own the pins |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_si | output | 1 | Serial feed into the boundary chain |
| bsr_so | input | 1 | Serial return from the boundary chain |
| usr_in | input | 8 | Value captured into the private register |
| usr_out | output | 8 | Value last updated from the private register |

## Verification
The pass-through opcodes get random 16-bit streams; the one-clock delay and the leading zero show that exactly one cell sits in the path. The private register is tried with random capture values and random shift-in values. This tells capture apart from update and shows that `usr_out` holds through the shift. Directed patterns cover the rest. The identification word shows that the bit order is LSB first. A 128-cell bench chain with a known capture image shows the boundary routing and strobe counts. A run of five high `tms` bits from inside Shift-DR confirms the reset path.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR     = 4'h0, ST_RTI     = 4'h1,
    ST_SEL_DR  = 4'h2, ST_CAP_DR  = 4'h3, ST_SH_DR  = 4'h4, ST_EX1_DR = 4'h5,
    ST_PAU_DR  = 4'h6, ST_EX2_DR  = 4'h7, ST_UPD_DR = 4'h8,
    ST_SEL_IR  = 4'h9, ST_CAP_IR  = 4'hA, ST_SH_IR  = 4'hB, ST_EX1_IR = 4'hC,
    ST_PAU_IR  = 4'hD, ST_EX2_IR  = 4'hE, ST_UPD_IR = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_BND_DRIVE  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT      = 3'b001;
  localparam logic [IR_W-1:0] OP_BND_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_PRIVATE    = 3'b011;
  localparam logic [IR_W-1:0] OP_PASS_A     = 3'b100;
  localparam logic [IR_W-1:0] OP_FLOAT      = 3'b101;
  localparam logic [IR_W-1:0] OP_PASS_B     = 3'b110;
  localparam logic [IR_W-1:0] OP_PASS       = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE    = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= nxt;
  end

  // Checker: run length of high tms, saturating at five.
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      hi_run <= 3'd0;
    else if (!tms)   hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  p_five_high_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run == 3'd5) |-> (state == ST_TLR));
  p_tlr_sticky_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  logic [IR_W-1:0] sh_q, sh_d, ir_d;

  always_comb begin
    sh_d = sh_q;
    ir_d = ir_q;
    if (state == ST_CAP_IR)     sh_d = IR_CAPTURE;
    else if (state == ST_SH_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
    if (state == ST_TLR)        ir_d = OP_IDENT;
    else if (state == ST_UPD_IR) ir_d = sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir_q <= OP_IDENT;
    end else begin
      sh_q <= sh_d;
      ir_q <= ir_d;
    end
  end

  assign ir_lsb = sh_q[0];

  p_ir_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));
  p_tlr_ident_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir_q == OP_IDENT));
endmodule

// File: rtl/tap_dr_bank.sv
module tap_dr_bank
  import tap_pkg::*;
#(
  parameter int          USR_W  = 8,
  parameter int          ID_W   = 32,
  parameter logic [31:0] ID_VAL = 32'h204D0067
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic [IR_W-1:0]  ir,
  input  logic             tdi,
  input  logic             bsr_so,
  input  logic [USR_W-1:0] usr_in,
  output logic [USR_W-1:0] usr_out,
  output logic             sel_bnd,
  output logic             dr_lsb
);
  logic sel_pass, sel_id, sel_usr;
  logic cap, shf, upd;
  logic             byp_q, byp_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [USR_W-1:0] us_q, us_d, uo_d;

  always_comb begin
    sel_id   = (ir == OP_IDENT);
    sel_usr  = (ir == OP_PRIVATE);
    sel_bnd  = (ir == OP_BND_DRIVE) || (ir == OP_BND_SAMPLE);
    sel_pass = !(sel_id || sel_usr || sel_bnd);
    cap = (state == ST_CAP_DR);
    shf = (state == ST_SH_DR);
    upd = (state == ST_UPD_DR);
  end

  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    us_d  = us_q;
    uo_d  = usr_out;
    if (sel_pass && cap)      byp_d = 1'b0;
    else if (sel_pass && shf) byp_d = tdi;
    if (sel_id && cap)        id_d = ID_VAL[ID_W-1:0];
    else if (sel_id && shf)   id_d = {tdi, id_q[ID_W-1:1]};
    if (sel_usr && cap)       us_d = usr_in;
    else if (sel_usr && shf)  us_d = {tdi, us_q[USR_W-1:1]};
    if (sel_usr && upd)       uo_d = us_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q   <= 1'b0;
      id_q    <= '0;
      us_q    <= '0;
      usr_out <= '0;
    end else begin
      byp_q   <= byp_d;
      id_q    <= id_d;
      us_q    <= us_d;
      usr_out <= uo_d;
    end
  end

  always_comb begin
    if (sel_pass)     dr_lsb = byp_q;
    else if (sel_id)  dr_lsb = id_q[0];
    else if (sel_usr) dr_lsb = us_q[0];
    else              dr_lsb = bsr_so;
  end

  p_usr_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_DR) |=> $stable(usr_out));
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int USR_W = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  output logic [2:0]       ir_o,
  output logic             core_hiz,
  output logic             bnd_drive,
  output logic             bsr_capture,
  output logic             bsr_shift,
  output logic             bsr_update,
  output logic             bsr_si,
  input  logic             bsr_so,
  input  logic [USR_W-1:0] usr_in,
  output logic [USR_W-1:0] usr_out
);
  logic rs_a, rst_n;
  tap_state_e state;
  logic [IR_W-1:0] ir;
  logic ir_lsb, dr_lsb, sel_bnd;
  logic tdo_d, en_d;

  // Reset asserts at once, releases on a rising tck edge.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rs_a  <= 1'b0;
      rst_n <= 1'b0;
    end else begin
      rs_a  <= 1'b1;
      rst_n <= rs_a;
    end
  end

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
               .ir_q(ir), .ir_lsb(ir_lsb));

  tap_dr_bank #(.USR_W(USR_W)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .ir(ir), .tdi(tdi),
    .bsr_so(bsr_so), .usr_in(usr_in), .usr_out(usr_out),
    .sel_bnd(sel_bnd), .dr_lsb(dr_lsb));

  always_comb begin
    ir_o        = ir;
    core_hiz    = (ir == OP_FLOAT);
    bnd_drive   = (ir == OP_BND_DRIVE);
    bsr_si      = tdi;
    bsr_capture = sel_bnd && (state == ST_CAP_DR);
    bsr_shift   = sel_bnd && (state == ST_SH_DR);
    bsr_update  = sel_bnd && (state == ST_UPD_DR);
    en_d  = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_d = 1'b0;
    if (state == ST_SH_IR)      tdo_d = ir_lsb;
    else if (state == ST_SH_DR) tdo_d = dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= en_d;
    end
  end

  p_tdo_en_shift_r10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));
  p_strobe_excl_r8: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));
  p_mode_excl_r11: assert property (@(posedge tck) disable iff (!rst_n)
    !(core_hiz && bnd_drive));
endmodule

// File: tb/tb_jtag_tap_ctrl.sv
module tb_jtag_tap_ctrl;
  logic tck, trst_n, tms, tdi, bsr_so;
  logic tdo, tdo_en, core_hiz, bnd_drive, bsr_capture, bsr_shift, bsr_update, bsr_si;
  logic [2:0] ir_o;
  logic [7:0] usr_in, usr_out;
  int checks, errors, edge_err, upd_cnt, cap_cnt;
  bit done;

  jtag_tap_ctrl dut (.*);

  initial tck = 1'b0;
  always #10 tck = ~tck;

  // External 128-cell chain model.
  localparam logic [127:0] CHAIN_IMG = {4{32'hA5C3_1E77}};
  logic [127:0] chain;
  assign bsr_so = chain[0];
  always @(posedge tck) begin
    if (bsr_capture) begin chain <= CHAIN_IMG; cap_cnt++; end
    else if (bsr_shift) chain <= {bsr_si, chain[127:1]};
    if (bsr_update) upd_cnt++;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pass(input logic [15:0] d);
    return {d[14:0], 1'b0};
  endfunction

  task automatic step(input logic m, input logic d, output logic o);
    o = tdo; tms = m; tdi = d;
    @(posedge tck); #2;
    if (tdo !== o) edge_err++;
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] capt, output logic [2:0] ir_before);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 3; i++) begin step(i == 2, op[i], o); capt[i] = o; end
    ir_before = ir_o;
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input int n, input logic [139:0] din, output logic [139:0] dout,
                          output logic [7:0] uo_before);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin step(i == n - 1, din[i], o); dout[i] = o; end
    uo_before = usr_out;
    step(1, 0, o); step(0, 0, o);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic o;
    logic [2:0] capt, irb;
    logic [139:0] din, dout;
    logic [7:0] uob, prev_uo;
    logic [2:0] pass_ops [4];
    checks = 0; errors = 0; edge_err = 0; upd_cnt = 0; cap_cnt = 0; done = 0;
    pass_ops[0] = 3'b111; pass_ops[1] = 3'b100; pass_ops[2] = 3'b101; pass_ops[3] = 3'b110;
    void'($urandom(32'd5171));
    trst_n = 0; tms = 1; tdi = 0; usr_in = 8'h00;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 ir", ir_o, 3'b001);
    chk("R1 tdo_en", tdo_en, 1'b0);
    trst_n = 1;
    repeat (3) step(1, 0, o);
    step(0, 0, o);                                    // to Run-Test/Idle
    chk("R10 tdo_en idle", tdo_en, 1'b0);

    // R4 capture pattern, R6 identification word (IR still 001 after reset)
    load_ir(3'b001, capt, irb);
    chk("R4 ir capture", capt, 3'b001);
    shift_dr(32, '0, dout, uob);
    chk("R6 ident", dout[31:0], 32'h204D0067);

    // R5/R9 private register, directed then random
    usr_in = 8'h96;
    load_ir(3'b011, capt, irb);
    chk("R5 ir held during shift", irb, 3'b001);
    chk("R5 ir updated", ir_o, 3'b011);
    din = 140'h5A;
    prev_uo = usr_out;
    shift_dr(8, din, dout, uob);
    chk("R9 capture", dout[7:0], 8'h96);
    chk("R9 hold before update", uob, prev_uo);
    chk("R9 update", usr_out, 8'h5A);
    for (int k = 0; k < 8; k++) begin
      usr_in = 8'($urandom);
      din = 140'($urandom);
      prev_uo = usr_out;
      shift_dr(8, din, dout, uob);
      chk("R9 rand capture", dout[7:0], usr_in);
      chk("R9 rand hold", uob, prev_uo);
      chk("R9 rand update", usr_out, din[7:0]);
    end
    chk("R8 no strobes outside boundary", cap_cnt + upd_cnt, 0);

    // R7 pass-through, random opcode from the set and random data
    for (int k = 0; k < 12; k++) begin
      logic [2:0] op;
      op = pass_ops[$urandom % 4];
      load_ir(op, capt, irb);
      din = 140'($urandom);
      shift_dr(16, din, dout, uob);
      chk("R7 pass", dout[15:0], exp_pass(din[15:0]));
      chk("R11 float", core_hiz, op == 3'b101);
      chk("R11 drive", bnd_drive, 1'b0);
    end

    // R8 boundary sample then drive
    load_ir(3'b010, capt, irb);
    chk("R11 sample no drive", bnd_drive, 1'b0);
    din = {12'h0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210};
    shift_dr(128, din, dout, uob);
    chk("R8 chain out", dout[127:0], CHAIN_IMG);
    chk("R8 chain loaded", chain, din[127:0]);
    chk("R8 capture count", cap_cnt, 1);
    chk("R8 update count", upd_cnt, 1);
    load_ir(3'b000, capt, irb);
    chk("R11 drive", bnd_drive, 1'b1);
    chk("R11 no float", core_hiz, 1'b0);

    // R2 five high tms from Shift-DR with private opcode loaded
    load_ir(3'b011, capt, irb);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    chk("R10 tdo_en shift", tdo_en, 1'b1);
    repeat (4) step(1, 0, o);
    chk("R2 not yet", ir_o, 3'b011);
    step(1, 0, o);
    step(1, 0, o);
    chk("R2 reset via tms", ir_o, 3'b001);
    chk("R2 tdo_en", tdo_en, 1'b0);

    chk("R10 no change at rising edge", edge_err, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule